// File: doc/BRIEF.md
# System Clock Source Controller

This block holds the register state that chooses where the system clock comes from. It has one enable bit for each of three oscillators: a high-frequency internal oscillator, a 32 kHz oscillator and a low-frequency ring oscillator. It also holds a source select field and a power-of-two prescaler. Each oscillator reports a ready flag. A request to move the system clock to a source that is not both enabled and ready is refused. An accepted change lowers a clock-ready status bit. The old source stays active until a short synchronizer window has passed. Then the new source is adopted and clock-ready rises again.

Reset is not a single event here. An asynchronous power-on reset and four synchronous reset kinds each restore a different subset of the state. From the prescaled system clock the block derives a bus clock enable at the system rate and a peripheral clock enable at half of that rate. The analog oscillators themselves are outside the block; only their ready flags come in.

Software-side writes arrive as a single-cycle strobe with a field address and data. There is no back-pressure: every strobe is taken in the cycle it is presented.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: A write to field 0 loads the enable bits (bit 0 high-frequency, bit 1 32 kHz, bit 2 ring oscillator). The bit of the active source and the bit of the selected source stay set whatever is written.
- R2: A write to field 1 with code 0 (high-frequency), 1 (32 kHz) or 2 (ring) is accepted only when that oscillator is both enabled and ready. Codes 3 to 7 and refused writes leave clk_sel, act_src and clk_rdy unchanged.
- R3: An accepted select write that changes clk_sel drives clk_rdy low after that edge, and act_src keeps the old source. After SYNC_STAGES further edges, act_src equals clk_sel and clk_rdy is high.
- R4: A select write accepted while a switch is pending replaces the target and restarts the synchronizer window. The earlier target never becomes active.
- R5: A write to field 2 loads the prescaler code p. ahb_ce is then high once every 2^p cycles, for p from 0 (every cycle) to 7 (1 in 128).
- R6: apb_ce is high on every second ahb_ce pulse only, so it is never high in two consecutive cycles.
- R7: While por_n is low, the enables are high-frequency on, 32 kHz off and ring on. The select is code 0, the prescaler is code 0 and clk_rdy is high.
- R8: A reset pulse of kind 0 (system) or 1 (watchdog) sets the high-frequency and ring enables and keeps the 32 kHz enable. It returns select, active source and prescaler to code 0 and sets clk_rdy.
- R9: A reset pulse of kind 2 (soft) or 3 (peripheral) sets the ring enable only and keeps everything else. Any reset pulse wins over a write in the same cycle and restarts the clock-enable phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pulse | input | 1 | One-cycle synchronous reset event |
| rst_kind | input | 2 | Kind of rst_pulse: 0 system, 1 watchdog, 2 soft, 3 peripheral |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 2 | Field: 0 enables, 1 select, 2 prescaler |
| wr_data | input | WD_W | Write data |
| osc_rdy | input | NUM_OSC | Oscillator ready flags |
| osc_en | output | NUM_OSC | Oscillator enable bits |
| clk_sel | output | SEL_W | Selected source field |
| act_src | output | SEL_W | Source currently driving the system clock |
| clk_rdy | output | 1 | High when no switch is pending |
| psc_code | output | PSC_W | Prescaler code (divide by 2^code) |
| ahb_ce | output | 1 | System-rate clock enable |
| apb_ce | output | 1 | Half-rate clock enable |

## Verification
The bench builds the block with its defaults: three oscillators, a 3-bit prescaler and a two-stage synchronizer. With these values the handshake can be checked edge by edge, and a replacement write can land inside the window. The full prescaler range up to a divide by 128 is reachable, and counting pulses over whole periods checks the bus enable ratios. All five reset kinds are applied from states that differ from their defaults, so that a kept field and a restored field can be told apart.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  // reset event kinds carried with rst_pulse
  typedef enum logic [1:0] {
    RK_SYSTEM   = 2'd0,
    RK_WATCHDOG = 2'd1,
    RK_SOFT     = 2'd2,
    RK_PERIPH   = 2'd3
  } rst_kind_e;

  // field addresses of the write port
  typedef enum logic [1:0] {
    FLD_ENABLE   = 2'd0,
    FLD_SELECT   = 2'd1,
    FLD_PRESCALE = 2'd2,
    FLD_NONE     = 2'd3
  } field_e;

  // oscillator positions; also their select codes
  localparam int OSC_HFI  = 0;
  localparam int OSC_K32  = 1;
  localparam int OSC_RING = 2;

endpackage

// File: rtl/sysclk_osc_en.sv
module sysclk_osc_en
  import sysclk_pkg::*;
#(
  parameter int NUM_OSC = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_pulse,
  input  logic [1:0]         rst_kind,
  input  logic               wr,
  input  logic [NUM_OSC-1:0] wdata,
  input  logic [NUM_OSC-1:0] keep,
  output logic [NUM_OSC-1:0] en
);

  localparam logic [NUM_OSC-1:0] POR_EN = NUM_OSC'((1 << OSC_HFI) | (1 << OSC_RING));

  logic hard_kind;
  assign hard_kind = (rst_kind == RK_SYSTEM) || (rst_kind == RK_WATCHDOG);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en <= POR_EN;
    end else if (rst_pulse) begin
      // ring oscillator comes back on after every reset kind
      en[OSC_RING] <= 1'b1;
      if (hard_kind) en[OSC_HFI] <= 1'b1;
    end else if (wr) begin
      // sources in use cannot be switched off
      en <= wdata | keep;
    end
  end

endmodule

// File: rtl/sysclk_sel_hs.sv
module sysclk_sel_hs #(
  parameter int NUM_OSC     = 3,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hard_rst,
  input  logic               wr,
  input  logic [SEL_W-1:0]   wcode,
  input  logic [NUM_OSC-1:0] osc_ok,
  output logic [SEL_W-1:0]   sel,
  output logic [SEL_W-1:0]   act,
  output logic               rdy
);

  logic [NUM_OSC-1:0]     tgt_mask;
  logic [SYNC_STAGES-1:0] sync;
  logic [SYNC_STAGES-1:0] sync_nxt;
  logic                   accept;

  // reserved codes match no oscillator and so are never accepted
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_tgt
    assign tgt_mask[g] = (wcode == SEL_W'(g));
  end

  assign accept   = wr && (|(tgt_mask & osc_ok)) && (wcode != sel);
  assign sync_nxt = {sync[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sel  <= '0;
      act  <= '0;
      rdy  <= 1'b1;
      sync <= '0;
    end else if (hard_rst) begin
      sel  <= '0;
      act  <= '0;
      rdy  <= 1'b1;
      sync <= '0;
    end else if (accept) begin
      // new or replaced target: restart the window
      sel  <= wcode;
      rdy  <= 1'b0;
      sync <= '0;
    end else if (!rdy) begin
      sync <= sync_nxt;
      if (sync_nxt[SYNC_STAGES-1]) begin
        act <= sel;
        rdy <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sysclk_ce_gen.sv
module sysclk_ce_gen #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             ahb_ce,
  output logic             apb_ce
);

  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

  logic [DIV_W-1:0] div;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] mask;
  logic             sys_ce;
  logic             apb_ph;

  assign span   = ONE << psc;
  assign mask   = DIV_W'(span - ONE);
  assign sys_ce = (div & mask) == '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      div    <= '0;
      apb_ph <= 1'b0;
    end else if (restart) begin
      div    <= '0;
      apb_ph <= 1'b0;
    end else begin
      div <= div + 1'b1;
      if (sys_ce) apb_ph <= ~apb_ph;
    end
  end

  assign ahb_ce = sys_ce;
  assign apb_ce = sys_ce & ~apb_ph;

endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import sysclk_pkg::*;
#(
  parameter int NUM_OSC     = 3,
  parameter int SEL_W       = 3,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int WD_A = (NUM_OSC > SEL_W) ? NUM_OSC : SEL_W,
  localparam int WD_W = (WD_A > PSC_W) ? WD_A : PSC_W
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_pulse,
  input  logic [1:0]         rst_kind,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [WD_W-1:0]    wr_data,
  input  logic [NUM_OSC-1:0] osc_rdy,
  output logic [NUM_OSC-1:0] osc_en,
  output logic [SEL_W-1:0]   clk_sel,
  output logic [SEL_W-1:0]   act_src,
  output logic               clk_rdy,
  output logic [PSC_W-1:0]   psc_code,
  output logic               ahb_ce,
  output logic               apb_ce
);

  logic               hard_rst;
  logic               wr_ok;
  logic               wr_enable, wr_select, wr_prescale;
  logic [NUM_OSC-1:0] keep_mask;
  logic [NUM_OSC-1:0] osc_ok;

  assign hard_rst    = rst_pulse && ((rst_kind == RK_SYSTEM) || (rst_kind == RK_WATCHDOG));
  assign wr_ok       = wr_en && !rst_pulse;
  assign wr_enable   = wr_ok && (wr_addr == FLD_ENABLE);
  assign wr_select   = wr_ok && (wr_addr == FLD_SELECT);
  assign wr_prescale = wr_ok && (wr_addr == FLD_PRESCALE);

  // a ready flag only counts while its enable is set
  assign osc_ok = osc_rdy & osc_en;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_keep
    assign keep_mask[g] = (act_src == SEL_W'(g)) || (clk_sel == SEL_W'(g));
  end

  sysclk_osc_en #(
    .NUM_OSC(NUM_OSC)
  ) u_osc_en (
    .clk      (clk),
    .por_n    (por_n),
    .rst_pulse(rst_pulse),
    .rst_kind (rst_kind),
    .wr       (wr_enable),
    .wdata    (wr_data[NUM_OSC-1:0]),
    .keep     (keep_mask),
    .en       (osc_en)
  );

  sysclk_sel_hs #(
    .NUM_OSC    (NUM_OSC),
    .SEL_W      (SEL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sel_hs (
    .clk     (clk),
    .por_n   (por_n),
    .hard_rst(hard_rst),
    .wr      (wr_select),
    .wcode   (wr_data[SEL_W-1:0]),
    .osc_ok  (osc_ok),
    .sel     (clk_sel),
    .act     (act_src),
    .rdy     (clk_rdy)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           psc_code <= '0;
    else if (hard_rst)    psc_code <= '0;
    else if (wr_prescale) psc_code <= wr_data[PSC_W-1:0];
  end

  sysclk_ce_gen #(
    .PSC_W(PSC_W)
  ) u_ce_gen (
    .clk    (clk),
    .por_n  (por_n),
    .restart(rst_pulse),
    .psc    (psc_code),
    .ahb_ce (ahb_ce),
    .apb_ce (apb_ce)
  );

endmodule

// File: rtl/sysclk_src_ctrl_chk.sv
module sysclk_src_ctrl_chk #(
  parameter int NUM_OSC = 3,
  parameter int SEL_W   = 3,
  parameter int PSC_W   = 3,
  parameter int WD_W    = 3
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_pulse,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [WD_W-1:0]    wr_data,
  input logic [NUM_OSC-1:0] osc_rdy,
  input logic [NUM_OSC-1:0] osc_en,
  input logic [SEL_W-1:0]   clk_sel,
  input logic [SEL_W-1:0]   act_src,
  input logic               clk_rdy,
  input logic [PSC_W-1:0]   psc_code,
  input logic               ahb_ce,
  input logic               apb_ce
);

  logic [NUM_OSC-1:0] req_mask;
  logic [NUM_OSC-1:0] act_mask;

  always_comb begin
    for (int i = 0; i < NUM_OSC; i++) begin
      req_mask[i] = (wr_data[SEL_W-1:0] == SEL_W'(i));
      act_mask[i] = (act_src == SEL_W'(i));
    end
  end

  // R2: a select write naming an unusable source leaves the field alone
  p_refuse_r2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_addr == 2'd1 && !rst_pulse && !(|(req_mask & osc_rdy & osc_en)))
    |=> $stable(clk_sel));

  // R3: a change of the select field outside reset comes with clk_rdy low
  p_rdy_drop_r3: assert property (@(posedge clk) disable iff (!por_n)
    (clk_sel != $past(clk_sel) && !$past(rst_pulse)) |-> !clk_rdy);

  // R3: the active source does not move while a switch is pending
  p_act_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    !clk_rdy |=> (clk_rdy || $stable(act_src)));

  // R3: when no switch is pending the active source is the selected one
  p_rdy_match_r3: assert property (@(posedge clk) disable iff (!por_n)
    clk_rdy |-> (act_src == clk_sel));

  // R1: the active source always has its enable set
  p_act_enabled_r1: assert property (@(posedge clk) disable iff (!por_n)
    |(act_mask & osc_en));

  // R6: half-rate enable never fires twice in a row
  p_apb_alt_r6: assert property (@(posedge clk) disable iff (!por_n)
    (apb_ce && !rst_pulse) |=> !apb_ce);

  // R5: at prescaler code 0 the system enable is always on
  p_ahb_full_r5: assert property (@(posedge clk) disable iff (!por_n)
    (psc_code == '0) |-> ahb_ce);

  // R9: ring oscillator enabled after any reset pulse
  p_ring_after_rst_r9: assert property (@(posedge clk) disable iff (!por_n)
    rst_pulse |=> osc_en[NUM_OSC-1]);

endmodule

bind sysclk_src_ctrl sysclk_src_ctrl_chk #(
  .NUM_OSC(NUM_OSC),
  .SEL_W  (SEL_W),
  .PSC_W  (PSC_W),
  .WD_W   (WD_W)
) u_chk (.*);

// File: tb/sysclk_src_ctrl_bench.sv
module sysclk_src_ctrl_bench;

  logic       clk = 1'b0;
  logic       por_n;
  logic       rst_pulse;
  logic [1:0] rst_kind;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [2:0] wr_data;
  logic [2:0] allow;
  logic [2:0] osc_rdy;
  logic [2:0] osc_en;
  logic [2:0] clk_sel;
  logic [2:0] act_src;
  logic       clk_rdy;
  logic [2:0] psc_code;
  logic       ahb_ce;
  logic       apb_ce;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  // ready only ever follows an enable
  assign osc_rdy = allow & osc_en;

  sysclk_src_ctrl u_sysclk_src_ctrl (
    .clk      (clk),
    .por_n    (por_n),
    .rst_pulse(rst_pulse),
    .rst_kind (rst_kind),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .osc_rdy  (osc_rdy),
    .osc_en   (osc_en),
    .clk_sel  (clk_sel),
    .act_src  (act_src),
    .clk_rdy  (clk_rdy),
    .psc_code (psc_code),
    .ahb_ce   (ahb_ce),
    .apb_ce   (apb_ce)
  );

  // {field, data, allow, expected enables, expected select, expected prescaler}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 3'd7, 3'b111, 3'b111, 3'd0, 3'd0},
    {2'd1, 3'd1, 3'b111, 3'b111, 3'd1, 3'd0},
    {2'd0, 3'd0, 3'b111, 3'b010, 3'd1, 3'd0},
    {2'd1, 3'd0, 3'b111, 3'b010, 3'd1, 3'd0},
    {2'd1, 3'd5, 3'b111, 3'b010, 3'd1, 3'd0},
    {2'd0, 3'd5, 3'b111, 3'b111, 3'd1, 3'd0},
    {2'd1, 3'd2, 3'b111, 3'b111, 3'd2, 3'd0},
    {2'd2, 3'd7, 3'b111, 3'b111, 3'd2, 3'd7},
    {2'd1, 3'd3, 3'b111, 3'b111, 3'd2, 3'd7},
    {2'd1, 3'd0, 3'b110, 3'b111, 3'd2, 3'd7},
    {2'd1, 3'd0, 3'b111, 3'b111, 3'd0, 3'd7},
    {2'd2, 3'd0, 3'b111, 3'b111, 3'd0, 3'd0}
  };

  task automatic chk(input string req, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rst(input logic [1:0] k);
    @(negedge clk);
    rst_pulse = 1'b1; rst_kind = k;
    @(negedge clk);
    rst_pulse = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int na, np;
    por_n = 1'b0; rst_pulse = 1'b0; rst_kind = 2'd0;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 3'd0; allow = 3'b111;
    repeat (3) @(negedge clk);
    // R7: power-on state while held
    chk("R7 en", int'(osc_en), 5);
    chk("R7 sel", int'(clk_sel), 0);
    chk("R7 psc", int'(psc_code), 0);
    chk("R7 rdy", int'(clk_rdy), 1);
    por_n = 1'b1;
    @(negedge clk);

    // table walk: R1 enables, R2 select gating, R5 prescaler field, R3 settle
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      allow = v[11:9];
      do_write(v[16:15], v[14:12]);
      repeat (4) @(negedge clk);
      chk("R1 enables", int'(osc_en), int'(v[8:6]));
      chk("R2 select", int'(clk_sel), int'(v[5:3]));
      chk("R5 prescaler", int'(psc_code), int'(v[2:0]));
      chk("R3 active", int'(act_src), int'(v[5:3]));
      chk("R3 ready", int'(clk_rdy), 1);
    end

    // R3: edge-by-edge handshake, 0 -> 2
    do_write(2'd1, 3'd2);
    chk("R3 rdy low", int'(clk_rdy), 0);
    chk("R3 old src", int'(act_src), 0);
    @(negedge clk);
    chk("R3 rdy still low", int'(clk_rdy), 0);
    chk("R3 old src held", int'(act_src), 0);
    @(negedge clk);
    chk("R3 new src", int'(act_src), 2);
    chk("R3 rdy back", int'(clk_rdy), 1);

    // R4: back-to-back writes 1 then 0
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 3'd1;
    @(negedge clk);
    wr_data = 3'd0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 target replaced", int'(clk_sel), 0);
    chk("R4 pending", int'(clk_rdy), 0);
    chk("R4 old src", int'(act_src), 2);
    @(negedge clk);
    chk("R4 window restarted", int'(act_src), 2);
    @(negedge clk);
    chk("R4 final src", int'(act_src), 0);
    chk("R4 rdy", int'(clk_rdy), 1);

    // R5/R6: enable ratios
    na = 0; np = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); na += int'(ahb_ce); np += int'(apb_ce);
    end
    chk("R5 ahb psc0", na, 8);
    chk("R6 apb psc0", np, 4);
    do_write(2'd2, 3'd2);
    @(negedge clk);
    na = 0; np = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk); na += int'(ahb_ce); np += int'(apb_ce);
    end
    chk("R5 ahb psc2", na, 8);
    chk("R6 apb psc2", np, 4);

    // R9: soft and peripheral resets
    do_write(2'd2, 3'd3);
    do_write(2'd1, 3'd1);
    repeat (3) @(negedge clk);
    do_write(2'd0, 3'd0);
    chk("R1 active kept", int'(osc_en), 2);
    do_rst(2'd2);
    chk("R9 soft en", int'(osc_en), 6);
    chk("R9 soft sel", int'(clk_sel), 1);
    chk("R9 soft psc", int'(psc_code), 3);
    chk("R9 soft act", int'(act_src), 1);
    do_write(2'd0, 3'd0);
    do_rst(2'd3);
    chk("R9 periph en", int'(osc_en), 6);
    chk("R9 periph sel", int'(clk_sel), 1);
    // R9: reset beats a write in the same cycle
    @(negedge clk);
    rst_pulse = 1'b1; rst_kind = 2'd2; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 3'd6;
    @(negedge clk);
    rst_pulse = 1'b0; wr_en = 1'b0;
    chk("R9 write dropped", int'(psc_code), 3);

    // R8: watchdog reset
    do_rst(2'd1);
    chk("R8 wdt en", int'(osc_en), 7);
    chk("R8 wdt sel", int'(clk_sel), 0);
    chk("R8 wdt act", int'(act_src), 0);
    chk("R8 wdt psc", int'(psc_code), 0);

    // R8: system reset after leaving high-frequency off
    do_write(2'd1, 3'd1);
    repeat (3) @(negedge clk);
    do_write(2'd0, 3'd0);
    do_write(2'd2, 3'd4);
    do_rst(2'd0);
    chk("R8 sys en", int'(osc_en), 7);
    chk("R8 sys sel", int'(clk_sel), 0);
    chk("R8 sys psc", int'(psc_code), 0);
    chk("R8 sys rdy", int'(clk_rdy), 1);

    // R7: power-on clears the 32 kHz enable
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    chk("R7 por en", int'(osc_en), 5);
    por_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule